// File: doc/BRIEF.md
# Dual-Timer APB Register Bank

This block is an APB slave holding two down-counting timer channels in a 4 KB address window. Each channel has a 32-byte register slice for its reload value, current count, control byte, interrupt clear, raw status, masked status and a background reload that leaves the running count alone. Counting advances on a shared one-cycle tick strobe, so any prescaling is done by whatever drives that strobe. Each channel drives its own interrupt line, and a third line is the OR of the two.

For board bring-up, a test-control register can take the interrupt lines away from the timers and drive them from a two-bit test-output register. Twelve fixed identification bytes sit at the top of the window, and all other offsets read as zero.

Reads are captured in the APB setup phase and presented during the access phase, with PREADY held high. Writes take effect on the access phase. Only aligned 32-bit accesses are decoded.

Top module: `dt_apb_bank`

## Requirements
- R1: After reset each channel's control reads 0x20 (interrupt enable set, timer stopped, 16-bit, free-running), its load reads 0, its value reads 0x0000FFFF and its raw status reads 0. The test-control register (0xF00) and the test-output register (0xF04) read 0, and all interrupt lines are low.
- R2: Channel n occupies 0x20*n. A write to offset 0x0 sets both the load and the count. A write to offset 0x18 sets only the load. Offsets 0x0 and 0x18 both read the load.
- R3: When control bit 7 (enable) is set, each tick lowers the count by one. Bit 1 selects 32-bit width (1) or 16-bit width (0). In 16-bit mode only the low 16 bits count, and offset 0x4 returns them zero-extended.
- R4: When a tick moves the count from 1 to 0, the raw status at offset 0x10 becomes 1. On a tick at count 0, the count reloads from the load register when bit 6 (periodic) is set, and otherwise wraps to all ones of the current width.
- R5: When control bit 0 (one-shot) is set, the count stays at 0 once it gets there.
- R6: Offset 0x14 reads raw status AND control bit 5 (interrupt enable). Outside test mode, each channel's interrupt line equals its masked status.
- R7: The combined interrupt line is always the OR of the two channel lines.
- R8: A write of any data to offset 0xC clears that channel's raw status.
- R9: While bit 0 of 0xF00 is set, channel 0's line follows bit 0 of 0xF04 and channel 1's line follows bit 1. Both registers read back their bits.
- R10: The words 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Unmapped offsets, including the interrupt-clear offset, read 0. Writes to unmapped offsets change nothing.
- R12: The control register keeps only bits 0, 1, 2, 3, 5, 6 and 7 (mask 0xEF). PREADY is always high, and read data appears in the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, registered |
| pready_o | output | 1 | APB ready, tied high |
| tick_i | input | 1 | Count strobe shared by both channels |
| irq_ch_o | output | 2 | Per-channel interrupt lines |
| irq_any_o | output | 1 | OR of the channel interrupt lines |

## Verification
A wrong count or reload value shows up on the next read of the value offset, and a missed 1-to-0 step shows up as a raw status and interrupt line still low one tick after the expected expiry. Decode faults appear at the next read of the affected word. The bench sweeps all identification words, a spread of unmapped offsets and every test-output pattern. It repeats the full channel sequence for each channel, so a cross-channel decode error shows as a changed register in the other slice.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
  // word offsets inside a channel slice
  localparam logic [2:0] OFF_LOAD   = 3'd0;
  localparam logic [2:0] OFF_VALUE  = 3'd1;
  localparam logic [2:0] OFF_CTRL   = 3'd2;
  localparam logic [2:0] OFF_CLR    = 3'd3;
  localparam logic [2:0] OFF_RAW    = 3'd4;
  localparam logic [2:0] OFF_MASKED = 3'd5;
  localparam logic [2:0] OFF_BG     = 3'd6;

  // global word addresses (byte address >> 2)
  localparam logic [9:0] W_ITCR     = 10'h3C0;
  localparam logic [9:0] W_ITOP     = 10'h3C1;
  localparam logic [9:0] W_ID_FIRST = 10'h3F4;

  localparam int CTRL_ONESHOT = 0;
  localparam int CTRL_SIZE    = 1;
  localparam int CTRL_INTEN   = 5;
  localparam int CTRL_MODE    = 6;
  localparam int CTRL_EN      = 7;
  localparam logic [7:0] CTRL_VALID = 8'hEF;
  localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/dt_id_rom.sv
`timescale 1ns/1ps
module dt_id_rom (
  input  logic [3:0] idx_i,
  output logic [7:0] word_o
);
  always_comb begin
    unique case (idx_i)
      4'd0:    word_o = 8'h04;
      4'd4:    word_o = 8'h23;
      4'd5:    word_o = 8'hB8;
      4'd6:    word_o = 8'h1B;
      4'd8:    word_o = 8'h0D;
      4'd9:    word_o = 8'hF0;
      4'd10:   word_o = 8'h05;
      4'd11:   word_o = 8'hB1;
      default: word_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/dt_channel.sv
`timescale 1ns/1ps
module dt_channel
  import dt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_load_i,
  input  logic              wr_bg_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] value_o,
  output logic [7:0]        ctrl_o,
  output logic              raw_o,
  output logic              masked_o
);
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);

  logic [DATA_W-1:0] load_q, cnt_q, mask, cur, reload_val;
  logic [7:0]        ctrl_q;
  logic              raw_q, step, expire;

  assign mask       = ctrl_q[CTRL_SIZE] ? '1 : HALF_MASK;
  assign cur        = cnt_q & mask;
  assign reload_val = ctrl_q[CTRL_MODE] ? (load_q & mask) : mask;
  assign step       = tick_i & ctrl_q[CTRL_EN] & ~wr_load_i;
  assign expire     = step & (cur == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
      cnt_q  <= '1;
      raw_q  <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= wdata_i[7:0] & CTRL_VALID;
      if (wr_bg_i || wr_load_i) load_q <= wdata_i;
      if (wr_load_i) begin
        cnt_q <= wdata_i;
      end else if (step) begin
        if (cur == '0) begin
          if (!ctrl_q[CTRL_ONESHOT]) cnt_q <= (cnt_q & ~mask) | reload_val;
        end else begin
          cnt_q <= (cnt_q & ~mask) | ((cur - ONE) & mask);
        end
      end
      // a clear wins over a coincident expiry
      if (wr_clr_i)    raw_q <= 1'b0;
      else if (expire) raw_q <= 1'b1;
    end
  end

  assign load_o   = load_q;
  assign value_o  = cur;
  assign ctrl_o   = ctrl_q;
  assign raw_o    = raw_q;
  assign masked_o = raw_q & ctrl_q[CTRL_INTEN];
endmodule

// File: rtl/dt_apb_bank.sv
`timescale 1ns/1ps
module dt_apb_bank
  import dt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  input  logic              tick_i,
  output logic [NUM_CH-1:0] irq_ch_o,
  output logic              irq_any_o
);
  localparam int CH_W = ADDR_W - 5;
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   waddr;
  logic [CH_W-1:0]   ch_sel;
  logic [2:0]        ch_off;
  logic              aligned, wr_acc, rd_setup;
  logic              itcr_q;
  logic [NUM_CH-1:0] itop_q;
  logic [NUM_CH-1:0] ch_raw, ch_masked;
  logic [DATA_W-1:0] ch_load [NUM_CH];
  logic [DATA_W-1:0] ch_value[NUM_CH];
  logic [7:0]        ch_ctrl [NUM_CH];
  logic [3:0]        id_idx;
  logic [7:0]        id_word;
  logic [DATA_W-1:0] rd_val, prdata_q;

  assign waddr    = paddr_i[ADDR_W-1:2];
  assign ch_sel   = paddr_i[ADDR_W-1:5];
  assign ch_off   = paddr_i[4:2];
  assign aligned  = (paddr_i[1:0] == 2'b00);
  assign wr_acc   = psel_i & penable_i & pwrite_i & aligned;
  assign rd_setup = psel_i & ~penable_i & ~pwrite_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_acc & (ch_sel == CH_W'(i));
    dt_channel #(.DATA_W(DATA_W), .HALF_W(DATA_W/2)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .wr_load_i (hit & (ch_off == OFF_LOAD)),
      .wr_bg_i   (hit & (ch_off == OFF_BG)),
      .wr_ctrl_i (hit & (ch_off == OFF_CTRL)),
      .wr_clr_i  (hit & (ch_off == OFF_CLR)),
      .wdata_i   (pwdata_i),
      .load_o    (ch_load[i]),
      .value_o   (ch_value[i]),
      .ctrl_o    (ch_ctrl[i]),
      .raw_o     (ch_raw[i]),
      .masked_o  (ch_masked[i])
    );
  end

  assign id_idx = 4'(waddr - WA_W'(W_ID_FIRST));

  dt_id_rom u_id (
    .idx_i  (id_idx),
    .word_o (id_word)
  );

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (waddr == WA_W'(W_ITCR)) rd_val = DATA_W'(itcr_q);
      if (waddr == WA_W'(W_ITOP)) rd_val = DATA_W'(itop_q);
      if (waddr >= WA_W'(W_ID_FIRST)) rd_val = DATA_W'(id_word);
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == CH_W'(i)) begin
          unique case (ch_off)
            OFF_LOAD, OFF_BG: rd_val = ch_load[i];
            OFF_VALUE:        rd_val = ch_value[i];
            OFF_CTRL:         rd_val = DATA_W'(ch_ctrl[i]);
            OFF_RAW:          rd_val = DATA_W'(ch_raw[i]);
            OFF_MASKED:       rd_val = DATA_W'(ch_masked[i]);
            default:          rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      itcr_q   <= 1'b0;
      itop_q   <= '0;
      prdata_q <= '0;
    end else begin
      if (wr_acc && waddr == WA_W'(W_ITCR)) itcr_q <= pwdata_i[0];
      if (wr_acc && waddr == WA_W'(W_ITOP)) itop_q <= pwdata_i[NUM_CH-1:0];
      if (rd_setup) prdata_q <= rd_val;
    end
  end

  assign prdata_o  = prdata_q;
  assign pready_o  = 1'b1;
  assign irq_ch_o  = itcr_q ? itop_q : ch_masked;
  assign irq_any_o = |irq_ch_o;
endmodule

// File: rtl/dt_apb_bank_chk.sv
`timescale 1ns/1ps
module dt_apb_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [DATA_W-1:0] prdata_o,
  input logic              pready_o,
  input logic [NUM_CH-1:0] irq_ch_o,
  input logic              irq_any_o,
  input logic              itcr_q,
  input logic [NUM_CH-1:0] itop_q
);
  logic rd_setup, gap_addr;
  assign rd_setup = psel_i & ~penable_i & ~pwrite_i;
  assign gap_addr = (paddr_i >= ADDR_W'(12'h040)) && (paddr_i < ADDR_W'(12'hF00));

  a_r7_any_is_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o == |irq_ch_o);

  a_r9_test_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itcr_q |-> irq_ch_o == itop_q);

  a_r11_gap_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_setup && gap_addr) |=> prdata_o == '0);

  a_r12_ready_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o);

  a_r10_id_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_setup && paddr_i == ADDR_W'(12'hFE0)) |=> prdata_o == DATA_W'(32'h23));
endmodule

bind dt_apb_bank dt_apb_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .prdata_o  (prdata_o),
  .pready_o  (pready_o),
  .irq_ch_o  (irq_ch_o),
  .irq_any_o (irq_any_o),
  .itcr_q    (itcr_q),
  .itop_q    (itop_q)
);

// File: tb/dt_apb_bank_tb_top.sv
`timescale 1ns/1ps
module dt_apb_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0, tick_i = 1'b0;
  logic [11:0] paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o;
  logic [1:0]  irq_ch_o;
  logic        irq_any_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dt_apb_bank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; penable_i = 1'b0; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1'b1;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; penable_i = 1'b0; paddr_i = a;
    @(negedge clk_i);
    penable_i = 1'b1;
    d = prdata_o;
    chk("R12 pready", {31'b0, pready_o}, 32'h1);
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic irq_chk(input string req, input logic [1:0] exp);
    @(negedge clk_i);
    chk(req, {30'b0, irq_ch_o}, {30'b0, exp});
    chk("R7 any", {31'b0, irq_any_o}, {31'b0, |exp});
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] id_exp [12];
    id_exp = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8, 8'h1B, 8'h00,
               8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      logic [11:0] b;
      b = 12'(c * 32);
      rchk("R1 ctrl", b + 12'h08, 32'h20);
      rchk("R1 load", b + 12'h00, 32'h0);
      rchk("R1 value", b + 12'h04, 32'h0000FFFF);
      rchk("R1 raw", b + 12'h10, 32'h0);
    end
    rchk("R1 itcr", 12'hF00, 32'h0);
    rchk("R1 itop", 12'hF04, 32'h0);
    irq_chk("R1 irq", 2'b00);

    // R10 identification sweep, then try to overwrite one word
    for (int k = 0; k < 12; k++) rchk("R10 id", 12'(12'hFD0 + 4 * k), {24'b0, id_exp[k]});
    wr(12'hFE0, 32'hFFFFFFFF);
    rchk("R10 id after write", 12'hFE0, 32'h23);

    // R11 unmapped reads and writes
    for (int a = 12'h040; a < 12'hF00; a += 12'h0C4) rchk("R11 gap read", 12'(a), 32'h0);
    rchk("R11 ch0 hole", 12'h01C, 32'h0);
    rchk("R11 ch1 hole", 12'h03C, 32'h0);
    rchk("R11 clr reads zero", 12'h00C, 32'h0);
    rchk("R11 top gap", 12'hF08, 32'h0);
    rchk("R11 below id", 12'hFCC, 32'h0);
    wr(12'h01C, 32'hFFFFFFFF);
    wr(12'h040, 32'hFFFFFFFF);
    wr(12'hF08, 32'hFFFFFFFF);
    rchk("R11 ch0 load kept", 12'h000, 32'h0);
    rchk("R11 ch0 ctrl kept", 12'h008, 32'h20);
    rchk("R11 itcr kept", 12'hF00, 32'h0);
    rchk("R11 itop kept", 12'hF04, 32'h0);

    // R9 integration test drive, all patterns
    wr(12'hF00, 32'hFFFFFFFF);
    rchk("R9 itcr readback", 12'hF00, 32'h1);
    for (int p = 0; p < 4; p++) begin
      wr(12'hF04, 32'hFFFFFFFC | 32'(p));
      rchk("R9 itop readback", 12'hF04, 32'(p));
      irq_chk("R9 irq forced", 2'(p));
    end
    wr(12'hF04, 32'h0);
    wr(12'hF00, 32'h0);
    irq_chk("R9 irq released", 2'b00);

    for (int c = 0; c < 2; c++) begin
      logic [11:0] b;
      logic [1:0]  bit_c;
      b = 12'(c * 32);
      bit_c = 2'(1 << c);
      rchk("R1 value untouched", b + 12'h04, 32'h0000FFFF);
      // R2 load and background load
      wr(b + 12'h00, 32'h3);
      rchk("R2 load", b + 12'h00, 32'h3);
      rchk("R2 value", b + 12'h04, 32'h3);
      // R3 R4 periodic, 32 bit, irq enabled
      wr(b + 12'h08, 32'hE2);
      ticks(2);
      rchk("R3 count down", b + 12'h04, 32'h1);
      rchk("R4 raw low", b + 12'h10, 32'h0);
      ticks(1);
      rchk("R4 reach zero", b + 12'h04, 32'h0);
      rchk("R4 raw set", b + 12'h10, 32'h1);
      rchk("R6 masked set", b + 12'h14, 32'h1);
      irq_chk("R6 irq", bit_c);
      ticks(1);
      rchk("R4 periodic reload", b + 12'h04, 32'h3);
      wr(b + 12'h18, 32'h5);
      rchk("R2 bg load", b + 12'h18, 32'h5);
      rchk("R2 bg keeps value", b + 12'h04, 32'h3);
      // R8 clear with zero data
      wr(b + 12'h0C, 32'h0);
      rchk("R8 raw cleared", b + 12'h10, 32'h0);
      irq_chk("R8 irq low", 2'b00);
      // R6 interrupt masked
      wr(b + 12'h08, 32'hC2);
      ticks(3);
      rchk("R6 raw set masked", b + 12'h10, 32'h1);
      rchk("R6 masked low", b + 12'h14, 32'h0);
      irq_chk("R6 irq masked", 2'b00);
      wr(b + 12'h0C, 32'hFFFFFFFF);
      rchk("R8 cleared again", b + 12'h10, 32'h0);
      // R4 free-running 16-bit wrap
      wr(b + 12'h08, 32'h80);
      ticks(1);
      rchk("R4 free wrap 16", b + 12'h04, 32'h0000FFFF);
      // R3 16-bit view of a wide load
      wr(b + 12'h00, 32'h12345678);
      rchk("R3 16-bit value", b + 12'h04, 32'h00005678);
      rchk("R3 full load", b + 12'h00, 32'h12345678);
      ticks(1);
      rchk("R3 16-bit step", b + 12'h04, 32'h00005677);
      // R5 one-shot
      wr(b + 12'h00, 32'h2);
      wr(b + 12'h08, 32'hA1);
      ticks(2);
      rchk("R5 reached zero", b + 12'h04, 32'h0);
      irq_chk("R5 irq", bit_c);
      ticks(3);
      rchk("R5 holds zero", b + 12'h04, 32'h0);
      wr(b + 12'h0C, 32'h0);
      // R3 disabled counter ignores ticks
      wr(b + 12'h08, 32'h20);
      wr(b + 12'h00, 32'h4);
      ticks(2);
      rchk("R3 disabled holds", b + 12'h04, 32'h4);
      // R12 control mask
      wr(b + 12'h08, 32'hFFFFFFFF);
      rchk("R12 ctrl mask", b + 12'h08, 32'hEF);
      wr(b + 12'h08, 32'h20);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule